// File: doc/BRIEF.md
# Receive Packet Stream Multiplexer

This block takes received transaction-layer packets, already split into a 128-bit descriptor, zero or more 64-bit payload words, per-word byte enables and a BAR-hit code, and streams each packet to the application over one 82-bit output bus. The low 64 bits of that bus are time-shared. The first beat carries the upper descriptor half, the second beat carries the lower half, and any later beats carry payload words. Sideband fields in the upper bits mark packet edges and carry the BAR code and byte enables on the beats where they mean something.

Packets enter through a valid/ready beat stream. The input is ready whenever both internal class queues have room, and a beat moves on any cycle where valid and ready are both high. The output is not a zero-latency handshake. The application raises `out_ready` to say it can take data. The block may drive `out_valid` high in a cycle only if `out_ready` was high three cycles earlier. The application must take every beat shown with `out_valid` high, so it must have room for the three beats still in flight after it drops ready. Non-posted packets go into one queue and posted or completion packets go into another. An `np_mask` input stops non-posted packets from starting, and packets from the other queue can pass a held non-posted packet.

Top module: `rx_stream_mux`

## Requirements
- R1: `out_beat` layout: [81:74] byte enables, [73] start flag, [72] end flag, [71:64] BAR code, [63:0] descriptor or payload.
- R2: Beat 0 of a packet carries descriptor [127:64]. Beat 1 carries descriptor [63:0]. Beats 2 onward carry the payload words in input order.
- R3: The start flag is high only on beat 0 and the end flag only on the last beat. A packet with no payload ends on beat 1. The two flags are never high on the same beat.
- R4: The BAR field is nonzero only on beat 1, where it equals the packet's BAR code. The byte-enable field is zero on beats 0 and 1 and equals the word's byte enables on payload beats.
- R5: `out_valid` is high in cycle t only if `out_ready` was high in cycle t-3. Every beat shown with `out_valid` high counts as accepted.
- R6: Each input packet appears on the output exactly once, with no beat lost or repeated.
- R7: No non-posted packet starts in a cycle that directly follows a cycle with `np_mask` high. A non-posted packet that has already started finishes even while the mask is high.
- R8: Packets of the same class leave in arrival order. With the mask low, all packets leave in arrival order. With the mask high, posted and completion packets pass non-posted packets that are waiting.
- R9: After reset, `out_valid` is low and `in_ready` is high.
- R10: `out_beat` is all zeros in every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| in_head | input | 1 | Beat carries the descriptor (1) or a payload word (0) |
| in_last | input | 1 | Final input beat of the packet |
| in_np | input | 1 | Packet is non-posted (read on descriptor beats only) |
| in_bar | input | 8 | BAR-hit code (read on descriptor beats only) |
| in_be | input | 8 | Byte enables of the payload word |
| in_word | input | 128 | Descriptor, or a payload word in bits [63:0] |
| np_mask | input | 1 | Hold back new non-posted packets |
| out_ready | input | 1 | Application can take data (valid follows three cycles later) |
| out_valid | output | 1 | Output beat present, must be accepted |
| out_beat | output | 82 | Output beat, layout per R1 |

## Verification
The bench goes after header-only packets. A design that gets these wrong either adds a payload beat or fails to raise the end flag on the low descriptor half. It also lets `out_ready` drop at random, so a ready pipeline that is off by one cycle shows up as a beat presented without the matching ready three cycles earlier. Directed mask sequences check three cases: a held non-posted packet that wrongly starts under the mask, posted packets that fail to pass it, and a non-posted packet cut off by a mask raised partway through it. A free-running random phase with the mask toggling checks for lost, duplicated or reordered packets within each class.

// File: rtl/rxm_pkg.sv
package rxm_pkg;
  localparam int WORD_W = 64;
  localparam int DESC_W = 2 * WORD_W;
  localparam int BE_W   = 8;
  localparam int BAR_W  = 8;
  localparam int BEAT_W = BE_W + 2 + BAR_W + WORD_W;
  localparam int NCLS   = 2;
  localparam int CLS_PC = 0;
  localparam int CLS_NP = 1;

  // one queued input beat
  typedef struct packed {
    logic [DESC_W-1:0] word;
    logic [BE_W-1:0]   be;
    logic [BAR_W-1:0]  bar;
    logic              head;
    logic              last;
  } rxm_entry_t;

  // one output beat, field order is the bus layout
  typedef struct packed {
    logic [BE_W-1:0]   be;
    logic              sop;
    logic              eop;
    logic [BAR_W-1:0]  bar;
    logic [WORD_W-1:0] data;
  } rxm_beat_t;
endpackage

// File: rtl/rxm_fifo.sv
module rxm_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/rxm_rdy_delay.sv
// Gives the permission to register an output beat, so that valid in
// cycle t follows ready from cycle t-LAT.
module rxm_rdy_delay #(
  parameter int LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy_in,
  output logic send_ok
);
  generate
    if (LAT <= 1) begin : g_direct
      assign send_ok = rdy_in;
    end else begin : g_pipe
      logic [LAT-2:0] pipe;
      always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe, rdy_in};
      end
      assign send_ok = pipe[LAT-2];
    end
  endgenerate
endmodule

// File: rtl/rxm_sched.sv
module rxm_sched
  import rxm_pkg::*;
#(
  parameter int SEQ_W = 5,
  parameter int FW    = SEQ_W + $bits(rxm_entry_t)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              send_ok,
  input  logic              np_mask,
  input  logic [FW-1:0]     head_np,
  input  logic [FW-1:0]     head_pc,
  input  logic              empty_np,
  input  logic              empty_pc,
  output logic              pop_np,
  output logic              pop_pc,
  output logic              out_valid,
  output logic [BEAT_W-1:0] out_beat
);
  rxm_entry_t       e_np, e_pc, cur_e;
  logic [SEQ_W-1:0] s_np, s_pc, sdiff;
  logic             np_ok, pc_ok, pick_np, start, cont, cur_empty;
  logic             busy_q, sel_q;
  rxm_beat_t        beat_d;

  assign {s_np, e_np} = head_np;
  assign {s_pc, e_pc} = head_pc;

  // oldest first by wrapping sequence number; mask only blocks new starts
  assign sdiff   = s_np - s_pc;
  assign np_ok   = !empty_np && !np_mask;
  assign pc_ok   = !empty_pc;
  assign pick_np = np_ok && (!pc_ok || sdiff[SEQ_W-1]);

  assign cur_e     = sel_q ? e_np : e_pc;
  assign cur_empty = sel_q ? empty_np : empty_pc;
  assign start     = send_ok && !busy_q && (np_ok || pc_ok);
  assign cont      = send_ok && busy_q && !cur_empty;
  assign pop_np    = cont && sel_q;
  assign pop_pc    = cont && !sel_q;

  always_comb begin
    beat_d = '0;
    if (start) begin
      // upper descriptor half; header entry stays queued for the next beat
      beat_d.sop  = 1'b1;
      beat_d.data = pick_np ? e_np.word[DESC_W-1:WORD_W] : e_pc.word[DESC_W-1:WORD_W];
    end else if (cont) begin
      beat_d.eop  = cur_e.last;
      beat_d.data = cur_e.word[WORD_W-1:0];
      if (cur_e.head) beat_d.bar = cur_e.bar;
      else            beat_d.be  = cur_e.be;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      sel_q     <= 1'b0;
      out_valid <= 1'b0;
      out_beat  <= '0;
    end else begin
      if (start) begin
        busy_q <= 1'b1;
        sel_q  <= pick_np;
      end else if (cont && cur_e.last) begin
        busy_q <= 1'b0;
      end
      out_valid <= start || cont;
      out_beat  <= beat_d;
    end
  end
endmodule

// File: rtl/rx_stream_mux.sv
module rx_stream_mux
  import rxm_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LAT   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_head,
  input  logic              in_last,
  input  logic              in_np,
  input  logic [BAR_W-1:0]  in_bar,
  input  logic [BE_W-1:0]   in_be,
  input  logic [DESC_W-1:0] in_word,
  input  logic              np_mask,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BEAT_W-1:0] out_beat
);
  localparam int SEQ_W = $clog2(2 * DEPTH) + 1;
  localparam int FW    = SEQ_W + $bits(rxm_entry_t);

  logic             accept, tgt_np, cur_np_q, send_ok;
  logic [SEQ_W-1:0] seq_q;
  rxm_entry_t       wr_e;
  logic [FW-1:0]    wr_data;
  logic [FW-1:0]    rd_data [NCLS];
  logic [NCLS-1:0]  push, pop, empty, full;

  assign in_ready = ~|full;
  assign accept   = in_valid && in_ready;
  assign tgt_np   = in_head ? in_np : cur_np_q;

  assign wr_e.word = in_word;
  assign wr_e.be   = in_be;
  assign wr_e.bar  = in_bar;
  assign wr_e.head = in_head;
  assign wr_e.last = in_last;
  assign wr_data   = {seq_q, wr_e};

  assign push[CLS_NP] = accept && tgt_np;
  assign push[CLS_PC] = accept && !tgt_np;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_np_q <= 1'b0;
      seq_q    <= '0;
    end else if (accept && in_head) begin
      cur_np_q <= in_np;
      seq_q    <= seq_q + 1'b1;
    end
  end

  generate
    for (genvar c = 0; c < NCLS; c++) begin : g_cls
      rxm_fifo #(.WIDTH(FW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push[c]),
        .din   (wr_data),
        .pop   (pop[c]),
        .dout  (rd_data[c]),
        .empty (empty[c]),
        .full  (full[c])
      );
    end
  endgenerate

  rxm_rdy_delay #(.LAT(LAT)) u_rdy (
    .clk     (clk),
    .rst_n   (rst_n),
    .rdy_in  (out_ready),
    .send_ok (send_ok)
  );

  rxm_sched #(.SEQ_W(SEQ_W), .FW(FW)) u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .send_ok   (send_ok),
    .np_mask   (np_mask),
    .head_np   (rd_data[CLS_NP]),
    .head_pc   (rd_data[CLS_PC]),
    .empty_np  (empty[CLS_NP]),
    .empty_pc  (empty[CLS_PC]),
    .pop_np    (pop[CLS_NP]),
    .pop_pc    (pop[CLS_PC]),
    .out_valid (out_valid),
    .out_beat  (out_beat)
  );
endmodule

// File: rtl/rx_stream_mux_chk.sv
module rx_stream_mux_chk
  import rxm_pkg::*;
#(
  parameter int LAT = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_ready,
  input logic              out_valid,
  input logic [BEAT_W-1:0] out_beat
);
  rxm_beat_t      b;
  logic [LAT-1:0] hist;
  logic           in_pkt;
  logic [1:0]     idx_q, cur_idx;

  assign b       = out_beat;
  assign cur_idx = in_pkt ? idx_q : 2'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist   <= '0;
      in_pkt <= 1'b0;
      idx_q  <= '0;
    end else begin
      hist <= (hist << 1) | LAT'(out_ready);
      if (out_valid) begin
        if (b.eop) begin
          in_pkt <= 1'b0;
          idx_q  <= '0;
        end else begin
          in_pkt <= 1'b1;
          if (b.sop)             idx_q <= 2'd1;
          else if (idx_q < 2'd2) idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> hist[LAT-1]);

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_beat == '0));

  p_sop_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !in_pkt) |-> (b.sop && !b.eop));

  p_sop_inside_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && in_pkt) |-> !b.sop);

  p_bar_second_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cur_idx != 2'd1) |-> (b.bar == '0));

  p_be_payload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cur_idx < 2'd2) |-> (b.be == '0));
endmodule

bind rx_stream_mux rx_stream_mux_chk #(.LAT(LAT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .out_beat  (out_beat)
);

// File: tb/tb_rx_stream_mux.sv
`timescale 1ns/1ps
module tb_rx_stream_mux;
  import rxm_pkg::*;
  localparam int NPK = 55;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_head = 1'b0, in_last = 1'b0, in_np = 1'b0;
  logic [7:0] in_bar = '0, in_be = '0;
  logic [127:0] in_word = '0;
  logic np_mask = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid;
  logic [81:0] out_beat;

  always #2 clk = ~clk;

  rx_stream_mux dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_head(in_head), .in_last(in_last), .in_np(in_np), .in_bar(in_bar),
    .in_be(in_be), .in_word(in_word), .np_mask(np_mask),
    .out_ready(out_ready), .out_valid(out_valid), .out_beat(out_beat)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  logic [127:0] p_desc [NPK];
  logic [7:0]   p_bar  [NPK];
  bit           p_np   [NPK];
  int           p_len  [NPK];
  logic [63:0]  p_w    [NPK][4];
  logic [7:0]   p_be   [NPK][4];

  int np_q [NPK], pc_q [NPK], sent_q [NPK], out_q [NPK];
  int np_wr = 0, pc_wr = 0, np_rd = 0, pc_rd = 0, sent_n = 0, out_n = 0;
  bit seen [NPK];
  bit gorder = 0;
  int next_g = 0, rx_cnt = 0;
  int m_idx = 0, m_id = 0, e_state = 0;
  bit e_mask_end = 0;
  bit [2:0] rh = '0;
  int rdy_mode = 1, mask_mode = 0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic gen_pkt(input int id, input bit np, input int len);
    p_np[id]   = np;
    p_len[id]  = len;
    p_desc[id] = {id[31:0], $urandom, $urandom, $urandom};
    p_bar[id]  = 8'($urandom % 255 + 1);
    for (int k = 0; k < 4; k++) begin
      p_w[id][k]  = {$urandom, $urandom};
      p_be[id][k] = 8'($urandom % 255 + 1);
    end
  endtask

  task automatic drive(input bit h, input bit l, input bit n, input logic [7:0] bar,
                       input logic [7:0] be, input logic [127:0] w);
    @(negedge clk);
    in_valid = 1'b1; in_head = h; in_last = l; in_np = n;
    in_bar = bar; in_be = be; in_word = w;
    while (!in_ready) @(negedge clk);
  endtask

  task automatic send_pkt(input int id);
    if (p_np[id]) np_q[np_wr++] = id; else pc_q[pc_wr++] = id;
    sent_q[sent_n++] = id;
    drive(1'b1, p_len[id] == 0, p_np[id], p_bar[id], 8'h00, p_desc[id]);
    for (int k = 0; k < p_len[id]; k++)
      drive(1'b0, k == p_len[id] - 1, 1'b0, 8'h00, p_be[id][k], {64'h0, p_w[id][k]});
    @(negedge clk);
    in_valid = 1'b0;
    repeat ($urandom % 3) @(negedge clk);
  endtask

  task automatic wait_rx(input int n);
    int t = 0;
    while (rx_cnt < n && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(rx_cnt >= n, "R6 packets missing", rx_cnt, n);
  endtask

  // application-side ready and mask drivers
  always @(negedge clk) begin
    out_ready = (rdy_mode == 1) ? 1'b1 : (($urandom % 10) < 7);
    if (mask_mode == 0)      np_mask = 1'b0;
    else if (mask_mode == 1) np_mask = 1'b1;
    else if ($urandom % 8 == 0) np_mask = ~np_mask;
  end

  // output monitor, samples after the edge has settled
  always @(posedge clk) begin
    logic [81:0] exp;
    int id, k;
    #1;
    if (!rst_n) begin
      rh = '0;
      m_idx = 0;
    end else begin
      rh = {rh[1:0], out_ready};
      if (!out_valid) begin
        chk(out_beat == '0, "R10 idle bus not zero", out_beat, 0);
      end else begin
        chk(rh[2], "R5 valid without ready three cycles earlier", out_valid, rh[2]);
        if (m_idx == 0) begin
          id = int'(out_beat[63:32]);
          if (id < 0 || id >= NPK) begin
            chk(0, "R6 unknown packet id", id, 0);
          end else begin
            exp = {8'h00, 1'b1, 1'b0, 8'h00, p_desc[id][127:64]};
            chk(out_beat == exp, "R2 first beat", out_beat, exp);
            chk(!seen[id], "R6 duplicate packet", id, 0);
            seen[id] = 1;
            out_q[out_n++] = id;
            if (p_np[id]) begin
              chk(!np_mask, "R7 non-posted started under mask", np_mask, 0);
              chk(np_q[np_rd] == id, "R8 non-posted order", id, np_q[np_rd]);
              np_rd++;
            end else begin
              chk(pc_q[pc_rd] == id, "R8 posted order", id, pc_q[pc_rd]);
              pc_rd++;
            end
            if (gorder) begin
              chk(sent_q[next_g] == id, "R8 arrival order", id, sent_q[next_g]);
              next_g++;
            end
            if (id == 54) e_state = 1;
            m_id = id;
            m_idx = 1;
          end
        end else if (m_idx == 1) begin
          exp = {8'h00, 1'b0, p_len[m_id] == 0, p_bar[m_id], p_desc[m_id][63:0]};
          chk(out_beat == exp, "R4 second beat", out_beat, exp);
          if (p_len[m_id] == 0) m_idx = 0; else m_idx = 2;
        end else begin
          k = m_idx - 2;
          if (k > 3) k = 3;
          exp = {p_be[m_id][k], 1'b0, k == p_len[m_id] - 1, 8'h00, p_w[m_id][k]};
          chk(out_beat == exp, "R1 payload beat", out_beat, exp);
          if (k >= p_len[m_id] - 1) m_idx = 0; else m_idx++;
        end
        if (m_idx == 0) begin
          rx_cnt++;
          if (m_id == 54) begin
            e_state = 2;
            e_mask_end = np_mask;
          end
        end
      end
    end
  end

  initial begin
    void'($urandom(32'h1d2c));
    for (int i = 0; i < NPK; i++) gen_pkt(i, $urandom % 2, $urandom % 4);
    p_len[0] = 0;
    p_len[1] = 0;
    gen_pkt(20, 1, 1); gen_pkt(21, 1, 1); gen_pkt(22, 0, 0); gen_pkt(23, 0, 1);
    gen_pkt(54, 1, 3);

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid, "R9 valid low after reset", out_valid, 0);
    chk(in_ready, "R9 ready high after reset", in_ready, 1);

    // random ready, mask low: global arrival order
    gorder = 1; rdy_mode = 0;
    for (int i = 0; i < 20; i++) send_pkt(i);
    wait_rx(20);
    gorder = 0;

    // mask held: posted packets pass held non-posted ones
    rdy_mode = 1; mask_mode = 1;
    repeat (2) @(negedge clk);
    for (int i = 20; i < 24; i++) send_pkt(i);
    wait_rx(22);
    repeat (10) @(negedge clk);
    chk(!seen[20] && !seen[21], "R7 masked non-posted held", {seen[20], seen[21]}, 0);
    chk(out_q[20] == 22 && out_q[21] == 23, "R8 posted bypass", {out_q[20], out_q[21]}, {32'd22, 32'd23});
    mask_mode = 0;
    wait_rx(24);
    chk(out_q[22] == 20 && out_q[23] == 21, "R8 non-posted resume order",
        {out_q[22], out_q[23]}, {32'd20, 32'd21});

    // random ready and random mask
    rdy_mode = 0; mask_mode = 2;
    for (int i = 24; i < 54; i++) send_pkt(i);
    mask_mode = 0;
    wait_rx(54);

    // mask raised after a non-posted packet has started
    rdy_mode = 1;
    fork
      send_pkt(54);
      begin
        wait (e_state == 1);
        mask_mode = 1;
      end
    join
    wait_rx(55);
    chk(e_mask_end, "R7 started packet completes under mask", e_mask_end, 1);
    chk(rx_cnt == NPK, "R6 total packets", rx_cnt, NPK);
    mask_mode = 0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired rx_cnt=%0d expected=%0d", rx_cnt, NPK);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule